// File: doc/BRIEF.md
# GPIO Pin Configuration Register Bank

This block holds the control state for a bank of general-purpose pins (94 by default) and exposes it on a 32-bit register bus. The bus uses a byte address, a request strobe and a one-cycle ready pulse. Two kinds of register share the address space. The first kind is the bitmapped words, which carry one bit per pin packed 32 to a word. These are an ownership map set from a parameter, interrupt enables and interrupt status, plus one routing bit. The second kind is a pair of configuration words for each pin. These select GPIO or native use, direction, output level, trigger style, input sensing and the weak pull.

From this state the block drives each pin's output level, output enable and pull code. It samples each pin's input through a two-flop synchroniser. It hands each pin's trigger style, armed state and a status-clear pulse to a separate interrupt block, which supplies the pending status bits in return.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset, every pin reads 0x00000005 in its first configuration word (GPIO use, input) and 0x00000004 in its second (sensing off). All interrupt enables are 0, and pad_oe, irq_arm and irq_clr are all 0.
- R2: The ownership words at 0x00, 0x04 and 0x08 read the OWN_MAP parameter, with pin n in word n/32 at bit n%32. Writes to these words are ignored. Bits for pins at or beyond NUM_PINS read 0.
- R3: The first configuration word of pin n sits at 0x100+8n. Bit 31 (output level), bit 4 (1 = level trigger, 0 = edge), bit 3 (invert sense), bit 2 (1 = input, 0 = output) and bit 0 (1 = GPIO, 0 = native) are read/write. All other bits except bit 30 read 0. A write touches only the addressed pin.
- R4: The second configuration word of pin n sits at 0x104+8n. Bit 2 (1 = input sensing off) and bits 1:0 (pull code) are read/write, and the other bits read 0. The pull code appears on pad_pull[2n+1:2n].
- R5: Bit 30 of the first configuration word shows the pin's input after a two-flop synchroniser and ignores writes. A read issued in the cycle the input changes still returns the old level.
- R6: While input sensing is off, bit 30 reads 0 and irq_arm for that pin is 0, whatever the pad input.
- R7: pad_oe[n] is 1 exactly when pin n is in GPIO use with direction output. pad_out[n] equals the output level while pad_oe[n] is 1 and is 0 otherwise.
- R8: irq_level_mode[n] and irq_invert[n] follow bits 4 and 3 of pin n's first configuration word.
- R9: The interrupt enable words at 0x90, 0x94 and 0x98 are read/write, one bit per pin, with unused bits dropped. irq_arm[n] is the enable bit ANDed with input sensing being on.
- R10: The status words at 0x80, 0x84 and 0x88 read irq_pend. Writing one to a bit raises the matching irq_clr bit for exactly one cycle.
- R11: Bit 0 of the word at 0x7C is a read/write routing select driven on irq_route. Its other bits read 0.
- R12: rsp_ready rises for exactly one cycle, one cycle after req_valid is sampled, with rsp_rdata valid in that cycle. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe, held until rsp_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_ready |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pull | output | 2*NUM_PINS | Weak pull code per pin |
| irq_level_mode | output | NUM_PINS | 1 = level trigger, 0 = edge |
| irq_invert | output | NUM_PINS | Trigger sense inverted |
| irq_arm | output | NUM_PINS | Pin may raise an interrupt |
| irq_route | output | 1 | Global interrupt routing select |
| irq_pend | input | NUM_PINS | Pending status from the interrupt block |
| irq_clr | output | NUM_PINS | One-cycle clear pulses for pending status |

## Verification
The assertions assume that a requester holds req_valid, req_write, req_addr and req_wdata steady until rsp_ready and drops req_valid in the ready cycle. Under that protocol, a ready pulse, an output-enable change or a clear pulse can only follow a sampled request. The bench tasks raise a request on a falling edge and read the response on the falling edge after the ready edge. They release the strobe at that same point, so no transfer overlaps another. Pad and pending inputs change only between transfers, and the synchroniser latency is measured from the cycle the input changes.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

    // per-pin stored configuration
    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       trig_inv;
        logic       dir_in;
        logic       gpio_sel;
        logic       sense_off;
        logic [1:0] pull;
    } pin_cfg_t;

    localparam pin_cfg_t PIN_CFG_RST = '{out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0,
                                         dir_in: 1'b1, gpio_sel: 1'b1, sense_off: 1'b1,
                                         pull: 2'b00};

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_OWN,
        RGN_ROUTE,
        RGN_STAT,
        RGN_IRQEN,
        RGN_CFG_A,
        RGN_CFG_B
    } region_t;

    // bus-visible layout
    localparam logic [31:0] OWN_BASE   = 32'h000;
    localparam logic [31:0] ROUTE_ADDR = 32'h07C;
    localparam logic [31:0] STAT_BASE  = 32'h080;
    localparam logic [31:0] IRQEN_BASE = 32'h090;
    localparam logic [31:0] CFG_BASE   = 32'h100;

    // bit positions inside the configuration words
    localparam int B_OUT   = 31;
    localparam int B_IN    = 30;
    localparam int B_TLVL  = 4;
    localparam int B_TINV  = 3;
    localparam int B_DIR   = 2;
    localparam int B_GPIO  = 0;
    localparam int B_SOFF  = 2;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PINS = 94,
    parameter int ADDR_W   = 12,
    localparam int WORDS   = (NUM_PINS + 31) / 32,
    localparam int WIDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic [WIDX_W-1:0] word_idx,
    output logic [PIN_W-1:0]  pin_idx
);
    localparam logic [31:0] BMAP_SPAN = 32'(4 * WORDS);
    localparam logic [31:0] CFG_SPAN  = 32'(8 * NUM_PINS);

    logic [31:0] a32;
    logic [31:0] off;

    always_comb begin
        a32      = 32'(addr);
        off      = '0;
        region   = RGN_NONE;
        word_idx = '0;
        pin_idx  = '0;
        if (a32 < OWN_BASE + BMAP_SPAN) begin
            region   = RGN_OWN;
            off      = a32 - OWN_BASE;
            word_idx = WIDX_W'(off >> 2);
        end else if (a32[31:2] == ROUTE_ADDR[31:2]) begin
            region = RGN_ROUTE;
        end else if (a32 >= STAT_BASE && a32 < STAT_BASE + BMAP_SPAN) begin
            region   = RGN_STAT;
            off      = a32 - STAT_BASE;
            word_idx = WIDX_W'(off >> 2);
        end else if (a32 >= IRQEN_BASE && a32 < IRQEN_BASE + BMAP_SPAN) begin
            region   = RGN_IRQEN;
            off      = a32 - IRQEN_BASE;
            word_idx = WIDX_W'(off >> 2);
        end else if (a32 >= CFG_BASE && a32 < CFG_BASE + CFG_SPAN) begin
            off     = a32 - CFG_BASE;
            pin_idx = PIN_W'(off >> 3);
            region  = off[2] ? RGN_CFG_B : RGN_CFG_A;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 94
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PINS = 94
) (
    input  pin_cfg_t [NUM_PINS-1:0]   cfg,
    input  logic [NUM_PINS-1:0]       irq_en,
    input  logic [NUM_PINS-1:0]       in_sync,
    output logic [NUM_PINS-1:0]       pad_out,
    output logic [NUM_PINS-1:0]       pad_oe,
    output logic [2*NUM_PINS-1:0]     pad_pull,
    output logic [NUM_PINS-1:0]       irq_level_mode,
    output logic [NUM_PINS-1:0]       irq_invert,
    output logic [NUM_PINS-1:0]       irq_arm,
    output logic [NUM_PINS-1:0]       in_seen
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic drive_en;
        logic sense_on;
        assign drive_en          = cfg[p].gpio_sel & ~cfg[p].dir_in;
        assign sense_on          = ~cfg[p].sense_off;
        assign pad_oe[p]         = drive_en;
        assign pad_out[p]        = drive_en & cfg[p].out_lvl;
        assign pad_pull[2*p+:2]  = cfg[p].pull;
        assign irq_level_mode[p] = cfg[p].trig_lvl;
        assign irq_invert[p]     = cfg[p].trig_inv;
        assign irq_arm[p]        = irq_en[p] & sense_on;
        assign in_seen[p]        = in_sync[p] & sense_on;
    end

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_cfg_pkg::*;
#(
    parameter int                  NUM_PINS = 94,
    parameter int                  ADDR_W   = 12,
    parameter logic [NUM_PINS-1:0] OWN_MAP  = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_ready,
    output logic [31:0]           rsp_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [2*NUM_PINS-1:0] pad_pull,
    output logic [NUM_PINS-1:0]   irq_level_mode,
    output logic [NUM_PINS-1:0]   irq_invert,
    output logic [NUM_PINS-1:0]   irq_arm,
    output logic                  irq_route,
    input  logic [NUM_PINS-1:0]   irq_pend,
    output logic [NUM_PINS-1:0]   irq_clr
);
    localparam int WORDS  = (NUM_PINS + 31) / 32;
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    typedef struct packed {
        pin_cfg_t [NUM_PINS-1:0] cfg;
        logic [NUM_PINS-1:0]     irq_en;
        logic [NUM_PINS-1:0]     clr;
        logic                    route;
        logic                    ready;
        logic [31:0]             rdata;
    } state_t;

    localparam state_t ST_RST = '{cfg: {NUM_PINS{PIN_CFG_RST}}, irq_en: '0, clr: '0,
                                  route: 1'b0, ready: 1'b0, rdata: '0};

    state_t st_d, st_q;

    region_t             region;
    logic [WIDX_W-1:0]   word_idx;
    logic [PIN_W-1:0]    pin_idx;
    logic [NUM_PINS-1:0] in_sync;
    logic [NUM_PINS-1:0] in_seen;
    logic [31:0]         rd_word;
    pin_cfg_t            sel_cfg;

    gpio_addr_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
        .addr     (req_addr),
        .region   (region),
        .word_idx (word_idx),
        .pin_idx  (pin_idx)
    );

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    gpio_pin_drive #(.NUM_PINS(NUM_PINS)) u_drive (
        .cfg            (st_q.cfg),
        .irq_en         (st_q.irq_en),
        .in_sync        (in_sync),
        .pad_out        (pad_out),
        .pad_oe         (pad_oe),
        .pad_pull       (pad_pull),
        .irq_level_mode (irq_level_mode),
        .irq_invert     (irq_invert),
        .irq_arm        (irq_arm),
        .in_seen        (in_seen)
    );

    // read mux
    always_comb begin
        rd_word = '0;
        sel_cfg = st_q.cfg[pin_idx];
        unique case (region)
            RGN_OWN: begin
                for (int i = 0; i < NUM_PINS; i++)
                    if ((i / 32) == int'(word_idx)) rd_word[i % 32] = OWN_MAP[i];
            end
            RGN_STAT: begin
                for (int i = 0; i < NUM_PINS; i++)
                    if ((i / 32) == int'(word_idx)) rd_word[i % 32] = irq_pend[i];
            end
            RGN_IRQEN: begin
                for (int i = 0; i < NUM_PINS; i++)
                    if ((i / 32) == int'(word_idx)) rd_word[i % 32] = st_q.irq_en[i];
            end
            RGN_ROUTE: rd_word[0] = st_q.route;
            RGN_CFG_A: begin
                rd_word[B_OUT]  = sel_cfg.out_lvl;
                rd_word[B_IN]   = in_seen[pin_idx];
                rd_word[B_TLVL] = sel_cfg.trig_lvl;
                rd_word[B_TINV] = sel_cfg.trig_inv;
                rd_word[B_DIR]  = sel_cfg.dir_in;
                rd_word[B_GPIO] = sel_cfg.gpio_sel;
            end
            RGN_CFG_B: begin
                rd_word[B_SOFF] = sel_cfg.sense_off;
                rd_word[1:0]    = sel_cfg.pull;
            end
            default: rd_word = '0;
        endcase
    end

    // next state
    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;
        st_d.clr   = '0;
        if (req_valid && !st_q.ready) begin
            st_d.ready = 1'b1;
            st_d.rdata = rd_word;
            if (req_write) begin
                unique case (region)
                    RGN_IRQEN: begin
                        for (int i = 0; i < NUM_PINS; i++)
                            if ((i / 32) == int'(word_idx)) st_d.irq_en[i] = req_wdata[i % 32];
                    end
                    RGN_STAT: begin
                        for (int i = 0; i < NUM_PINS; i++)
                            if ((i / 32) == int'(word_idx)) st_d.clr[i] = req_wdata[i % 32];
                    end
                    RGN_ROUTE: st_d.route = req_wdata[0];
                    RGN_CFG_A: begin
                        st_d.cfg[pin_idx].out_lvl  = req_wdata[B_OUT];
                        st_d.cfg[pin_idx].trig_lvl = req_wdata[B_TLVL];
                        st_d.cfg[pin_idx].trig_inv = req_wdata[B_TINV];
                        st_d.cfg[pin_idx].dir_in   = req_wdata[B_DIR];
                        st_d.cfg[pin_idx].gpio_sel = req_wdata[B_GPIO];
                    end
                    RGN_CFG_B: begin
                        st_d.cfg[pin_idx].sense_off = req_wdata[B_SOFF];
                        st_d.cfg[pin_idx].pull      = req_wdata[1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign rsp_ready = st_q.ready;
    assign rsp_rdata = st_q.rdata;
    assign irq_route = st_q.route;
    assign irq_clr   = st_q.clr;

endmodule

// File: rtl/gpio_cfg_bank_chk.sv
module gpio_cfg_bank_chk #(
    parameter int NUM_PINS = 94
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic                rsp_ready,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] irq_clr
);
    assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    assert_ready_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> $past(req_valid));

    assert_out_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    assert_oe_moves_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pad_oe) |-> (rsp_ready && $past(req_write)));

    assert_clr_from_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_clr) |-> (rsp_ready && $past(req_write)));

    assert_clr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_clr) |=> (irq_clr == '0));

endmodule

bind gpio_cfg_bank gpio_cfg_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_ready (rsp_ready),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_clr   (irq_clr)
);

// File: tb/gpio_cfg_bank_bench.sv
module gpio_cfg_bank_bench;
    localparam int NP = 94;
    localparam logic [NP-1:0] OWN = {30'h2AAA_AAAA, 32'hFFFF_00FF, 32'h7FFF_FFFE};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_ready;
    logic [31:0]     rsp_rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out;
    logic [NP-1:0]   pad_oe;
    logic [2*NP-1:0] pad_pull;
    logic [NP-1:0]   irq_level_mode;
    logic [NP-1:0]   irq_invert;
    logic [NP-1:0]   irq_arm;
    logic            irq_route;
    logic [NP-1:0]   irq_pend = '0;
    logic [NP-1:0]   irq_clr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic          ready_seen;
    logic          ready_gone;
    logic [NP-1:0] clr_seen;
    logic [NP-1:0] clr_after;

    always #10 clk = ~clk;

    gpio_cfg_bank #(.NUM_PINS(NP), .ADDR_W(12), .OWN_MAP(OWN)) u_gpio_cfg_bank (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
        .irq_level_mode(irq_level_mode), .irq_invert(irq_invert), .irq_arm(irq_arm),
        .irq_route(irq_route), .irq_pend(irq_pend), .irq_clr(irq_clr)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [11:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        ready_seen = rsp_ready;
        rd         = rsp_rdata;
        clr_seen   = irq_clr;
        req_valid  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        ready_gone = !rsp_ready;
        clr_after  = irq_clr;
    endtask

    function automatic logic [11:0] cfg_a(input int n);
        return 12'(32'h100 + 8 * n);
    endfunction

    function automatic logic [11:0] cfg_b(input int n);
        return 12'(32'h104 + 8 * n);
    endfunction

    task automatic t_reset();
        logic [31:0] rd;
        @(negedge clk);
        check(pad_oe == '0, "R1 pad_oe", 128'(pad_oe), 0);
        check(irq_arm == '0, "R1 irq_arm", 128'(irq_arm), 0);
        check(irq_clr == '0, "R1 irq_clr", 128'(irq_clr), 0);
        xfer(1'b0, cfg_a(0), 0, rd);
        check(rd == 32'h5, "R1 cfg_a pin0", 128'(rd), 128'h5);
        xfer(1'b0, cfg_b(93), 0, rd);
        check(rd == 32'h4, "R1 cfg_b pin93", 128'(rd), 128'h4);
        xfer(1'b0, 12'h94, 0, rd);
        check(rd == 32'h0, "R1 irq enable word", 128'(rd), 0);
    endtask

    task automatic t_own();
        logic [31:0] rd;
        xfer(1'b0, 12'h000, 0, rd);
        check(rd == OWN[31:0], "R2 own word0", 128'(rd), 128'(OWN[31:0]));
        xfer(1'b0, 12'h008, 0, rd);
        check(rd == {2'b00, OWN[93:64]}, "R2 own word2 top bits", 128'(rd), 128'(OWN[93:64]));
        xfer(1'b1, 12'h004, 32'h0, rd);
        xfer(1'b0, 12'h004, 0, rd);
        check(rd == OWN[63:32], "R2 own write ignored", 128'(rd), 128'(OWN[63:32]));
    endtask

    task automatic t_cfg_a();
        logic [31:0] rd;
        xfer(1'b1, cfg_a(5), 32'hFFFF_FFFF, rd);
        xfer(1'b0, cfg_a(5), 0, rd);
        check(rd == 32'h8000_001D, "R3 R5 cfg_a fields, bit30 ignores write", 128'(rd),
              128'h8000_001D);
        check(pad_oe[5] == 1'b0 && pad_out[5] == 1'b0, "R7 input pin not driven",
              128'({pad_oe[5], pad_out[5]}), 0);
        xfer(1'b0, cfg_a(4), 0, rd);
        check(rd == 32'h5, "R3 neighbour untouched", 128'(rd), 128'h5);
        xfer(1'b1, cfg_a(5), 32'h8000_0001, rd);
        @(negedge clk);
        check(pad_oe[5] == 1'b1 && pad_out[5] == 1'b1, "R7 gpio output drives",
              128'({pad_oe[5], pad_out[5]}), 128'h3);
        xfer(1'b1, cfg_a(5), 32'h8000_0000, rd);
        check(pad_oe[5] == 1'b0 && pad_out[5] == 1'b0, "R7 native use not driven",
              128'({pad_oe[5], pad_out[5]}), 0);
    endtask

    task automatic t_trig();
        logic [31:0] rd;
        xfer(1'b1, cfg_a(93), 32'h0000_001D, rd);
        check(irq_level_mode[93] && irq_invert[93], "R8 level+invert",
              128'({irq_level_mode[93], irq_invert[93]}), 128'h3);
        xfer(1'b1, cfg_a(93), 32'h0000_0015, rd);
        check(irq_level_mode[93] && !irq_invert[93], "R8 level only",
              128'({irq_level_mode[93], irq_invert[93]}), 128'h2);
        xfer(1'b1, cfg_a(93), 32'h0000_000D, rd);
        check(!irq_level_mode[93] && irq_invert[93], "R8 edge inverted",
              128'({irq_level_mode[93], irq_invert[93]}), 128'h1);
    endtask

    task automatic t_cfg_b();
        logic [31:0] rd;
        xfer(1'b1, cfg_b(40), 32'hFFFF_FFFF, rd);
        xfer(1'b0, cfg_b(40), 0, rd);
        check(rd == 32'h7, "R4 cfg_b fields", 128'(rd), 128'h7);
        check(pad_pull[81:80] == 2'b11, "R4 pull export", 128'(pad_pull[81:80]), 128'h3);
        xfer(1'b1, cfg_b(40), 32'h1, rd);
        xfer(1'b0, cfg_b(40), 0, rd);
        check(rd == 32'h1, "R4 sensing on, pull 1", 128'(rd), 128'h1);
    endtask

    task automatic t_sense();
        logic [31:0] rd;
        @(negedge clk);
        pad_in[40] = 1'b1;
        repeat (3) @(negedge clk);
        xfer(1'b0, cfg_a(40), 0, rd);
        check(rd == 32'h4000_0005, "R5 input seen", 128'(rd), 128'h4000_0005);
        pad_in[40] = 1'b0;
        xfer(1'b0, cfg_a(40), 0, rd);
        check(rd == 32'h4000_0005, "R5 synchroniser latency", 128'(rd), 128'h4000_0005);
        repeat (3) @(negedge clk);
        xfer(1'b0, cfg_a(40), 0, rd);
        check(rd == 32'h5, "R5 input low seen", 128'(rd), 128'h5);
        pad_in[40] = 1'b1;
        xfer(1'b1, 12'h094, 32'h0000_0100, rd);
        check(irq_arm[40] == 1'b1, "R9 armed with sensing", 128'(irq_arm[40]), 1);
        xfer(1'b1, cfg_b(40), 32'h4, rd);
        repeat (3) @(negedge clk);
        xfer(1'b0, cfg_a(40), 0, rd);
        check(rd == 32'h5, "R6 sensing off hides input", 128'(rd), 128'h5);
        check(irq_arm[40] == 1'b0, "R6 sensing off disarms", 128'(irq_arm[40]), 0);
        xfer(1'b0, 12'h094, 0, rd);
        check(rd == 32'h100, "R9 enable readback", 128'(rd), 128'h100);
        xfer(1'b1, 12'h098, 32'hFFFF_FFFF, rd);
        xfer(1'b0, 12'h098, 0, rd);
        check(rd == 32'h3FFF_FFFF, "R9 unused enable bits dropped", 128'(rd), 128'h3FFF_FFFF);
    endtask

    task automatic t_stat();
        logic [31:0] rd;
        irq_pend = {30'h0, 32'hDEAD_BEEF, 32'h0000_0012};
        xfer(1'b0, 12'h084, 0, rd);
        check(rd == 32'hDEAD_BEEF, "R10 status read", 128'(rd), 128'hDEAD_BEEF);
        xfer(1'b1, 12'h080, 32'h0000_0012, rd);
        check(clr_seen == NP'(32'h12), "R10 clear pulse", 128'(clr_seen), 128'h12);
        check(clr_after == '0, "R10 clear one cycle", 128'(clr_after), 0);
    endtask

    task automatic t_route();
        logic [31:0] rd;
        xfer(1'b1, 12'h07C, 32'hFFFF_FFFF, rd);
        xfer(1'b0, 12'h07C, 0, rd);
        check(rd == 32'h1 && irq_route, "R11 route bit", 128'({irq_route, rd}), 128'h1_0000_0001);
        xfer(1'b1, 12'h07C, 32'h0, rd);
        check(!irq_route, "R11 route cleared", 128'(irq_route), 0);
    endtask

    task automatic t_bus();
        logic [31:0] rd;
        xfer(1'b1, 12'h060, 32'hFFFF_FFFF, rd);
        xfer(1'b0, 12'h060, 0, rd);
        check(rd == 32'h0, "R12 unmapped reads zero", 128'(rd), 0);
        check(ready_seen && ready_gone, "R12 ready one-cycle pulse",
              128'({ready_seen, ready_gone}), 128'h3);
        xfer(1'b1, 12'h3F0, 32'h8000_0001, rd);
        check(pad_oe == NP'(0), "R12 past last pin ignored", 128'(pad_oe), 0);
        xfer(1'b0, cfg_a(93), 0, rd);
        check(rd == 32'h0000_000D, "R12 last pin intact", 128'(rd), 128'hD);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_own();
        t_cfg_a();
        t_trig();
        t_cfg_b();
        t_sense();
        t_stat();
        t_route();
        t_bus();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule